// File: doc/BRIEF.md
# Power-Cut-Safe PIN Verifier

This block checks a received PIN against a reference PIN and keeps a persistent count of failed attempts. The ordering of its steps removes any gain from cutting power mid-attempt. On a start strobe it captures both PINs and the stored failure count. It first asks nonvolatile storage to record the count plus one and waits for the write to be acknowledged. Then it compares every byte of the PIN, without stopping early. Last, it asks for a second write: the original count when the PINs match, or the incremented count again when they differ. A status word, a blocked flag and a one-cycle done pulse appear only after that second write has been acknowledged.

A user who watches for the result and then removes power has already paid for the attempt, because the increment is stored before anything about the result leaves the block. The compare phase lasts the same number of cycles for every input. Both outcomes issue two writes, so the visible sequence is the same whether the PIN is right or wrong. When the stored count has already reached the retry limit, the block refuses the attempt at once. It reports a distinct refusal code and touches neither the compare nor the storage.

Top module: `pin_verify_guard`

## Requirements
- R1: A start strobe sampled while idle, with a stored count below RETRY_LIMIT, raises the write request on the next cycle. The write data equals the stored count plus one.
- R2: A write request stays high, with unchanged data, until a cycle in which the acknowledge is high. It is low in the cycle after the acknowledge.
- R3: Between the acknowledge of the first write and the rise of the second request there are exactly PIN_BYTES cycles, whatever the PIN values are and wherever they differ.
- R4: The second write carries the captured stored count when all bytes match. It carries the stored count plus one when any byte differs.
- R5: done pulses high for exactly one cycle. For a verification it falls in the cycle after the second acknowledge, and status_o and blocked_o take their new values in that same cycle.
- R6: A match reports status 16'h9000. A mismatch reports 16'h63C0 with the tries left (RETRY_LIMIT minus the new count) in bits 3:0.
- R7: A start sampled while idle, with a stored count at or above RETRY_LIMIT, gives done on the next cycle with status 16'h6983 and blocked_o high. No write request is made.
- R8: blocked_o goes high when an attempt ends with the count at RETRY_LIMIT, or when an attempt is refused. A match clears it. It holds its value between attempts.
- R9: A start strobe while an attempt is in progress has no effect. The running attempt keeps the PINs and the count it captured, and no extra done appears.
- R10: After reset, the write request, done, blocked_o and status_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to verify |
| pin_rx_i | input | 8*PIN_BYTES | Received PIN, byte 0 in bits 7:0 |
| pin_ref_i | input | 8*PIN_BYTES | Reference PIN, same layout |
| cnt_stored_i | input | CNT_W | Failure count as held in nonvolatile storage |
| cnt_wr_ack_i | input | 1 | Storage has committed the requested write |
| cnt_wr_req_o | output | 1 | Request to write cnt_wr_data_o to storage |
| cnt_wr_data_o | output | CNT_W | Count value to be written |
| status_o | output | 16 | Result word of the last attempt |
| blocked_o | output | 1 | Count has reached the limit |
| done_o | output | 1 | One-cycle pulse: result is valid |

## Verification
A wrong internal state shows up at the storage handshake well before it reaches the status word. A comparer index that skipped or repeated a byte would show as a compare phase shorter or longer than PIN_BYTES cycles. A wrongly accumulated mismatch would change the second write value or the status. An early status release would show as done arriving without a preceding acknowledge. All of these appear within one attempt, about PIN_BYTES plus the two write latencies. A lost blocked flag or a stale captured count shows up on the very next start, as a write issued where a refusal was due or as a wrong first write value.

// File: rtl/pv_pkg.sv
package pv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WR_INC = 2'd1,
        ST_SCAN   = 2'd2,
        ST_WR_FIN = 2'd3
    } pv_state_e;

    localparam int          SW_W       = 16;
    localparam logic [15:0] SW_MATCH   = 16'h9000;
    localparam logic [15:0] SW_FAIL    = 16'h63C0;
    localparam logic [15:0] SW_REFUSED = 16'h6983;

endpackage

// File: rtl/pv_scan_cmp.sv
// Byte-serial PIN comparer: one byte per step, every byte always visited,
// mismatches OR-accumulated into one flag.
module pv_scan_cmp #(
    parameter int N_BYTES = 8,
    parameter int BYTE_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic                      step_i,
    input  logic [N_BYTES*BYTE_W-1:0] a_i,
    input  logic [N_BYTES*BYTE_W-1:0] b_i,
    output logic                      last_o,
    output logic                      miss_o
);
    localparam int VEC_W = N_BYTES * BYTE_W;
    localparam int IDX_W = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_BYTES - 1);

    typedef struct packed {
        logic [VEC_W-1:0] a;
        logic [VEC_W-1:0] b;
        logic [IDX_W-1:0] idx;
        logic             miss;
    } scan_regs_t;

    scan_regs_t           r_q, r_d;
    logic [N_BYTES-1:0]   diff_w;
    logic                 miss_now;

    for (genvar g = 0; g < N_BYTES; g++) begin : g_byte_diff
        assign diff_w[g] = |(r_q.a[g*BYTE_W +: BYTE_W] ^ r_q.b[g*BYTE_W +: BYTE_W]);
    end

    assign miss_now = r_q.miss | diff_w[r_q.idx];
    assign last_o   = (r_q.idx == IDX_LAST);
    assign miss_o   = miss_now;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.a    = a_i;
            r_d.b    = b_i;
            r_d.idx  = '0;
            r_d.miss = 1'b0;
        end else if (step_i) begin
            r_d.miss = miss_now;
            r_d.idx  = last_o ? '0 : r_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

endmodule

// File: rtl/pv_status_fmt.sv
// Builds the result word for a finished verification.
module pv_status_fmt #(
    parameter int CNT_W       = 4,
    parameter int RETRY_LIMIT = 3
) (
    input  logic             miss_i,
    input  logic [CNT_W-1:0] new_cnt_i,
    output logic [15:0]      word_o,
    output logic             at_limit_o
);
    import pv_pkg::*;

    localparam int REM_W = CNT_W + 1;
    localparam logic [REM_W-1:0] LIMIT_X = REM_W'(RETRY_LIMIT);

    logic [REM_W-1:0] rem_w;
    logic [3:0]       nib_w;

    always_comb begin
        rem_w      = (LIMIT_X > {1'b0, new_cnt_i}) ? (LIMIT_X - {1'b0, new_cnt_i}) : '0;
        nib_w      = (rem_w > REM_W'(15)) ? 4'hF : rem_w[3:0];
        at_limit_o = miss_i && ({1'b0, new_cnt_i} >= LIMIT_X);
        word_o     = miss_i ? (SW_FAIL | {12'h000, nib_w}) : SW_MATCH;
    end

endmodule

// File: rtl/pin_verify_guard.sv
module pin_verify_guard #(
    parameter int PIN_BYTES   = 8,
    parameter int CNT_W       = 4,
    parameter int RETRY_LIMIT = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [PIN_BYTES*8-1:0] pin_rx_i,
    input  logic [PIN_BYTES*8-1:0] pin_ref_i,
    input  logic [CNT_W-1:0]       cnt_stored_i,
    input  logic                   cnt_wr_ack_i,
    output logic                   cnt_wr_req_o,
    output logic [CNT_W-1:0]       cnt_wr_data_o,
    output logic [15:0]            status_o,
    output logic                   blocked_o,
    output logic                   done_o
);
    import pv_pkg::*;

    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(RETRY_LIMIT);

    typedef struct packed {
        pv_state_e        st;
        logic [CNT_W-1:0] base;
        logic [CNT_W-1:0] wr_data;
        logic             miss;
        logic [15:0]      status;
        logic             blocked;
        logic             done;
    } ctl_regs_t;

    ctl_regs_t   r_q, r_d;
    logic        load_w, step_w, last_w, miss_w;
    logic [15:0] fin_word_w;
    logic        fin_limit_w;
    logic        idle_w;

    pv_scan_cmp #(
        .N_BYTES (PIN_BYTES),
        .BYTE_W  (8)
    ) i_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_w),
        .step_i (step_w),
        .a_i    (pin_rx_i),
        .b_i    (pin_ref_i),
        .last_o (last_w),
        .miss_o (miss_w)
    );

    pv_status_fmt #(
        .CNT_W       (CNT_W),
        .RETRY_LIMIT (RETRY_LIMIT)
    ) i_fmt (
        .miss_i     (r_q.miss),
        .new_cnt_i  (r_q.wr_data),
        .word_o     (fin_word_w),
        .at_limit_o (fin_limit_w)
    );

    always_comb begin
        r_d    = r_q;
        r_d.done = 1'b0;
        load_w = 1'b0;
        step_w = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (cnt_stored_i >= LIMIT_C) begin
                        r_d.status  = SW_REFUSED;
                        r_d.blocked = 1'b1;
                        r_d.done    = 1'b1;
                    end else begin
                        load_w      = 1'b1;
                        r_d.base    = cnt_stored_i;
                        r_d.wr_data = cnt_stored_i + 1'b1;
                        r_d.st      = ST_WR_INC;
                    end
                end
            end
            ST_WR_INC: begin
                if (cnt_wr_ack_i) r_d.st = ST_SCAN;
            end
            ST_SCAN: begin
                step_w = 1'b1;
                if (last_w) begin
                    r_d.miss    = miss_w;
                    r_d.wr_data = miss_w ? r_q.base + 1'b1 : r_q.base;
                    r_d.st      = ST_WR_FIN;
                end
            end
            ST_WR_FIN: begin
                if (cnt_wr_ack_i) begin
                    r_d.status  = fin_word_w;
                    r_d.blocked = fin_limit_w;
                    r_d.done    = 1'b1;
                    r_d.st      = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign idle_w        = (r_q.st == ST_IDLE);
    assign cnt_wr_req_o  = (r_q.st == ST_WR_INC) || (r_q.st == ST_WR_FIN);
    assign cnt_wr_data_o = r_q.wr_data;
    assign status_o      = r_q.status;
    assign blocked_o     = r_q.blocked;
    assign done_o        = r_q.done;

endmodule

// File: rtl/pin_verify_guard_chk.sv
module pin_verify_guard_chk #(
    parameter int PIN_BYTES   = 8,
    parameter int CNT_W       = 4,
    parameter int RETRY_LIMIT = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             idle,
    input logic [CNT_W-1:0] cnt_stored,
    input logic             ack,
    input logic             req,
    input logic [CNT_W-1:0] wr_data,
    input logic [15:0]      status,
    input logic             blocked,
    input logic             done
);
    import pv_pkg::*;

    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(RETRY_LIMIT);
    localparam int GAP_W = $clog2(PIN_BYTES + 2) + 1;

    logic             phase_q;
    logic             run_q;
    logic [GAP_W-1:0] gap_q;
    logic [CNT_W-1:0] first_q;

    p_first_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle && cnt_stored < LIMIT_C) |=>
        (req && wr_data == CNT_W'($past(cnt_stored) + 1'b1)));

    p_hold_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> (req && $stable(wr_data)));

    p_release_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> !req);

    p_status_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != SW_REFUSED) |-> $past(req && ack));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle && cnt_stored >= LIMIT_C) |=>
        (done && !req && blocked && status == SW_REFUSED));

    p_match_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == SW_MATCH) |-> !blocked);

    p_no_req_when_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && done));

    // Compare-phase length and second-write value, tracked by counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            run_q   <= 1'b0;
            gap_q   <= '0;
            first_q <= '0;
        end else begin
            if (run_q && req) begin
                run_q <= 1'b0;
                p_scan_len_r3: assert (gap_q == GAP_W'(PIN_BYTES))
                    else $error("compare phase length %0d", gap_q);
                p_fin_value_r4: assert (wr_data == first_q || wr_data == CNT_W'(first_q - 1'b1))
                    else $error("second write value %0d", wr_data);
            end else if (run_q) begin
                gap_q <= gap_q + 1'b1;
            end
            if (req && ack) begin
                phase_q <= ~phase_q;
                if (!phase_q) begin
                    run_q   <= 1'b1;
                    gap_q   <= '0;
                    first_q <= wr_data;
                end
            end
        end
    end

endmodule

bind pin_verify_guard pin_verify_guard_chk #(
    .PIN_BYTES   (PIN_BYTES),
    .CNT_W       (CNT_W),
    .RETRY_LIMIT (RETRY_LIMIT)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .idle       (idle_w),
    .cnt_stored (cnt_stored_i),
    .ack        (cnt_wr_ack_i),
    .req        (cnt_wr_req_o),
    .wr_data    (cnt_wr_data_o),
    .status     (status_o),
    .blocked    (blocked_o),
    .done       (done_o)
);

// File: tb/test_pin_verify_guard.sv
module test_pin_verify_guard;
    localparam int PB = 8;
    localparam int CW = 4;
    localparam int LIM = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [PB*8-1:0] rx = '0;
    logic [PB*8-1:0] rf = '0;
    logic [CW-1:0]   cnt = '0;
    logic            ack = 1'b0;
    logic            req;
    logic [CW-1:0]   wdat;
    logic [15:0]     sw;
    logic            blk;
    logic            done;

    typedef struct {
        logic [15:0]   sw;
        logic          blk;
        int            nwr;
        logic [CW-1:0] w1;
        logic [CW-1:0] w2;
        int            start_cyc;
    } exp_t;

    exp_t          exp_q[$];
    logic [CW-1:0] wr_log[$];
    int            ack_cyc[$];
    int            req_cyc[$];
    int            cyc = 0;
    int            checks = 0;
    int            errors = 0;
    int            done_cnt = 0;
    int            ack_lat = 0;
    int            wcnt = 0;
    logic          req_prev = 1'b0;
    logic          finished = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pin_verify_guard #(.PIN_BYTES(PB), .CNT_W(CW), .RETRY_LIMIT(LIM)) i_pin_verify_guard (
        .clk(clk), .rst_n(rst_n), .start_i(start), .pin_rx_i(rx), .pin_ref_i(rf),
        .cnt_stored_i(cnt), .cnt_wr_ack_i(ack), .cnt_wr_req_o(req),
        .cnt_wr_data_o(wdat), .status_o(sw), .blocked_o(blk), .done_o(done));

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Storage model: acknowledges each request after ack_lat waiting cycles.
    always @(negedge clk) begin
        ack = 1'b0;
        if (req) begin
            if (!req_prev) req_cyc.push_back(cyc);
            if (wcnt >= ack_lat) begin
                ack = 1'b1;
                wr_log.push_back(wdat);
                ack_cyc.push_back(cyc);
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end
        req_prev = req;
    end

    // Monitor: pop the expected item at each done and compare.
    always @(negedge clk) begin
        if (rst_n && done) begin
            exp_t e;
            done_cnt++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected done", 1, 0);
            end else begin
                e = exp_q.pop_front();
                chk(sw == e.sw, "R6/R7 status", sw, e.sw);
                chk(blk == e.blk, "R8 blocked", blk, e.blk);
                chk(wr_log.size() == e.nwr, "R1/R7 write count", wr_log.size(), e.nwr);
                if (e.nwr == 2 && wr_log.size() == 2 && req_cyc.size() == 2) begin
                    chk(wr_log[0] == e.w1, "R1 first write", wr_log[0], e.w1);
                    chk(wr_log[1] == e.w2, "R4 second write", wr_log[1], e.w2);
                    chk(req_cyc[1] - ack_cyc[0] - 1 == PB, "R3 compare cycles",
                        req_cyc[1] - ack_cyc[0] - 1, PB);
                    chk(cyc - ack_cyc[1] == 1, "R5 done latency", cyc - ack_cyc[1], 1);
                end else if (e.nwr == 0) begin
                    chk(cyc - e.start_cyc == 1, "R7 refusal latency", cyc - e.start_cyc, 1);
                end
            end
            wr_log.delete();
            ack_cyc.delete();
            req_cyc.delete();
        end
    end

    task automatic attempt(input logic [PB*8-1:0] a, input logic [PB*8-1:0] b,
                           input logic [CW-1:0] c, input int lat, input bit poke);
        exp_t e;
        int   target;
        bit   miss;
        @(negedge clk);
        rx = a; rf = b; cnt = c; ack_lat = lat;
        miss = (a != b);
        if (c >= LIM) begin
            e.sw = 16'h6983; e.blk = 1'b1; e.nwr = 0; e.w1 = '0; e.w2 = '0;
        end else begin
            e.nwr = 2;
            e.w1  = c + 1'b1;
            e.w2  = miss ? c + 1'b1 : c;
            e.sw  = miss ? (16'h63C0 | 16'(LIM - (c + 1))) : 16'h9000;
            e.blk = miss && (c + 1 >= LIM);
        end
        e.start_cyc = cyc;
        exp_q.push_back(e);
        target = done_cnt + 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R9: a second strobe with different data while busy.
            repeat (2) @(negedge clk);
            rx = ~a; rf = b; cnt = CW'(LIM);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt < target) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [PB*8-1:0] pin;
        pin = 64'h3132_3334_3536_3738;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(req == 1'b0, "R10 reset req", req, 0);
        chk(done == 1'b0, "R10 reset done", done, 0);
        chk(blk == 1'b0, "R10 reset blocked", blk, 0);
        chk(sw == 16'h0, "R10 reset status", sw, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        attempt(pin, pin, 4'd0, 0, 1'b0);                         // match
        attempt(pin ^ 64'h0000_0000_0000_0001, pin, 4'd0, 2, 1'b0); // byte 0 differs
        attempt(pin ^ 64'h8000_0000_0000_0000, pin, 4'd1, 1, 1'b0); // byte 7 differs
        attempt(~pin, pin, 4'd2, 0, 1'b0);                        // all differ, reaches limit
        attempt(pin, pin, 4'd3, 0, 1'b0);                         // refused at limit
        attempt(pin, pin, 4'd15, 1, 1'b0);                        // refused far above limit
        attempt(pin, pin, 4'd2, 1, 1'b0);                         // match clears blocked
        attempt(pin, pin, 4'd0, 3, 1'b1);                         // busy strobe ignored
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R9 pending results", exp_q.size(), 0);
        chk(done_cnt == 8, "R9 done count", done_cnt, 8);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule